// File: doc/BRIEF.md
# ASCII I/O Command Decoder

This block sits behind a character receiver and turns a stream of ASCII bytes into control actions for a small digital I/O unit. Each command is one letter, then its arguments, then a carriage return (0x0D). The decoder supports three commands. A status read returns whether a change-of-state event was seen and asks the attached logic to clear that event. A mask write loads a per-input change-of-state enable mask given as hex digits. An edge-select command picks the rising or falling edge for one input, named by a decimal index.

Parsed fields leave the block on a parallel interface, each with a one-cycle write strobe. Every accepted command gets a reply that ends in a carriage return. The reply goes out one byte at a time over a valid/ready handshake. While a reply is pending the decoder holds its input ready low, so no character is lost.

Top module: `ioc_cmd_decoder`

## Requirements
- R1: After reset no strobe is active, tx_valid is low and rx_ready is high.
- R2: The read command, the letter Y (0x59) followed by CR, replies 'Y' (0x59) if cos_flag was high in the cycle the CR was accepted, and 'N' (0x4E) if it was low. The reply ends with CR (0x0D). It also raises cos_clr for one cycle.
- R3: The mask command is the letter T, then exactly N_BITS/4 hex digits with the most significant first, then CR. It raises mask_we for one cycle with mask_data equal to that value, and replies with a single CR.
- R4: Command letters (Y, T, D) and hex digits a-f are accepted in either case with the same result.
- R5: The edge command is the letter D, then a decimal index, then '+' (0x2B) or '-' (0x2D), then CR. It raises edge_we for one cycle with edge_idx equal to the index and edge_rise set to 1 for '+' and 0 for '-'. It replies with a single CR.
- R6: The index of the edge command may be one digit or two digits (for example "5" or "05"). Both forms give the same strobe and reply. Three or more digits are malformed.
- R7: A malformed command gives no strobe and no reply. Malformed means an unknown letter, a non-hex or missing/extra hex digit, a missing sign, an index of N_BITS or more, or extra characters before CR. Every character up to and including the next CR is dropped, and the following command decodes normally. A lone CR is ignored.
- R8: The strobe of a valid command and the first reply byte both appear in the cycle after the accepting of its CR.
- R9: Each reply byte is taken when tx_valid and tx_ready are both high. tx_data stays unchanged while tx_valid is high and tx_ready is low. rx_ready is low until the last reply byte has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Input character present |
| rx_data | input | 8 | Input ASCII character |
| rx_ready | output | 1 | Decoder can accept a character |
| cos_flag | input | 1 | Change-of-state event flag from the attached logic |
| cos_clr | output | 1 | One-cycle request to clear the event flag |
| mask_we | output | 1 | Change-of-state mask write strobe |
| mask_data | output | N_BITS | Mask value to write |
| edge_we | output | 1 | Edge-select write strobe |
| edge_idx | output | clog2(N_BITS) | Input index of the edge-select write |
| edge_rise | output | 1 | 1 = rising edge, 0 = falling edge |
| tx_valid | output | 1 | Reply byte present |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Downstream takes the reply byte |

## Verification
A character counts as accepted at the clock edge where rx_valid and rx_ready are both high. Strobes and the first reply byte of a command are due exactly one cycle after its CR is accepted. The driver checks them at the next falling edge after that acceptance. Reply bytes come out later, at times set by the randomly toggling tx_ready, so a monitor compares each byte at the falling edge before the handshake edge, in queue order. For malformed commands the bench watches the outputs for several cycles before sending the next command.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_PLUS  = 8'h2B;
    localparam logic [7:0] CH_MINUS = 8'h2D;
    localparam logic [7:0] CH_YES   = 8'h59;
    localparam logic [7:0] CH_NO    = 8'h4E;
    localparam logic [7:0] CH_LT    = 8'h54;
    localparam logic [7:0] CH_LD    = 8'h44;

    typedef enum logic [3:0] {
        PS_IDLE,
        PS_Y_END,
        PS_T_HEX,
        PS_D_FIRST,
        PS_D_SECOND,
        PS_D_SIGN,
        PS_D_END,
        PS_SKIP
    } pstate_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_MASK,
        OP_EDGE
    } op_e;

    typedef enum logic [1:0] {
        RK_ACK,
        RK_YES,
        RK_NO
    } reply_e;

    typedef struct packed {
        logic       is_cr;
        logic       is_hex;
        logic       is_dec;
        logic       is_plus;
        logic       is_minus;
        logic [3:0] hex_val;
        op_e        op;
    } chclass_t;

    function automatic logic [7:0] fold_upper(input logic [7:0] c);
        if (c >= 8'h61 && c <= 8'h7A) return c - 8'h20;
        return c;
    endfunction

    function automatic chclass_t classify(input logic [7:0] c);
        chclass_t   r;
        logic [7:0] u;
        u          = fold_upper(c);
        r          = '0;
        r.is_cr    = (c == CH_CR);
        r.is_plus  = (c == CH_PLUS);
        r.is_minus = (c == CH_MINUS);
        r.is_dec   = (c >= 8'h30 && c <= 8'h39);
        if (r.is_dec) begin
            r.is_hex  = 1'b1;
            r.hex_val = c[3:0];
        end else if (u >= 8'h41 && u <= 8'h46) begin
            r.is_hex  = 1'b1;
            r.hex_val = u[3:0] + 4'd9;
        end
        if (u == CH_YES)     r.op = OP_READ;
        else if (u == CH_LT) r.op = OP_MASK;
        else if (u == CH_LD) r.op = OP_EDGE;
        else                 r.op = OP_NONE;
        return r;
    endfunction

endpackage

// File: rtl/ioc_char_class.sv
module ioc_char_class
    import ioc_pkg::*;
(
    input  logic [7:0] ch,
    output chclass_t   cls
);
    always_comb cls = classify(ch);
endmodule

// File: rtl/ioc_parser.sv
module ioc_parser
    import ioc_pkg::*;
#(
    parameter int N_BITS = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  chclass_t          cls,
    input  logic              cos_flag,
    output logic              mask_we,
    output logic [N_BITS-1:0] mask_data,
    output logic              edge_we,
    output logic [IDX_W-1:0]  edge_idx,
    output logic              edge_rise,
    output logic              cos_clr,
    output logic              rep_req,
    output reply_e            rep_kind
);
    localparam int HEX_DIGITS = (N_BITS + 3) / 4;
    localparam int HEX_W      = 4 * HEX_DIGITS;
    localparam int CNT_W      = $clog2(HEX_DIGITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HEX_DIGITS);
    localparam logic [6:0]       IDX_LIM  = 7'(N_BITS);

    pstate_e          st;
    logic [HEX_W-1:0] hex_acc;
    logic [CNT_W-1:0] hex_cnt;
    logic [6:0]       idx_acc;
    logic             rise_q;
    logic             fire_rd, fire_mask, fire_edge;
    logic             is_sign;

    assign is_sign   = cls.is_plus | cls.is_minus;
    assign fire_rd   = acc && cls.is_cr && (st == PS_Y_END);
    assign fire_mask = acc && cls.is_cr && (st == PS_T_HEX) && (hex_cnt == CNT_FULL);
    assign fire_edge = acc && cls.is_cr && (st == PS_D_END);
    assign rep_req   = fire_rd | fire_mask | fire_edge;
    assign rep_kind  = fire_rd ? (cos_flag ? RK_YES : RK_NO) : RK_ACK;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= PS_IDLE;
            hex_acc   <= '0;
            hex_cnt   <= '0;
            idx_acc   <= '0;
            rise_q    <= 1'b0;
            mask_we   <= 1'b0;
            edge_we   <= 1'b0;
            cos_clr   <= 1'b0;
            mask_data <= '0;
            edge_idx  <= '0;
            edge_rise <= 1'b0;
        end else begin
            mask_we <= fire_mask;
            edge_we <= fire_edge;
            cos_clr <= fire_rd;
            if (fire_mask) mask_data <= hex_acc[N_BITS-1:0];
            if (fire_edge) begin
                edge_idx  <= idx_acc[IDX_W-1:0];
                edge_rise <= rise_q;
            end
            if (acc) begin
                case (st)
                    PS_IDLE: begin
                        hex_acc <= '0;
                        hex_cnt <= '0;
                        idx_acc <= '0;
                        if (!cls.is_cr) begin
                            case (cls.op)
                                OP_READ: st <= PS_Y_END;
                                OP_MASK: st <= PS_T_HEX;
                                OP_EDGE: st <= PS_D_FIRST;
                                default: st <= PS_SKIP;
                            endcase
                        end
                    end
                    PS_Y_END: st <= cls.is_cr ? PS_IDLE : PS_SKIP;
                    PS_T_HEX: begin
                        if (cls.is_cr) st <= PS_IDLE;
                        else if (cls.is_hex && hex_cnt != CNT_FULL) begin
                            hex_acc <= HEX_W'({hex_acc, cls.hex_val});
                            hex_cnt <= hex_cnt + 1'b1;
                        end else st <= PS_SKIP;
                    end
                    PS_D_FIRST: begin
                        if (cls.is_cr) st <= PS_IDLE;
                        else if (cls.is_dec) begin
                            idx_acc <= 7'(cls.hex_val);
                            st      <= PS_D_SECOND;
                        end else st <= PS_SKIP;
                    end
                    PS_D_SECOND: begin
                        if (cls.is_cr) st <= PS_IDLE;
                        else if (cls.is_dec) begin
                            idx_acc <= 7'(idx_acc * 7'd10) + 7'(cls.hex_val);
                            st      <= PS_D_SIGN;
                        end else if (is_sign && idx_acc < IDX_LIM) begin
                            rise_q <= cls.is_plus;
                            st     <= PS_D_END;
                        end else st <= PS_SKIP;
                    end
                    PS_D_SIGN: begin
                        if (cls.is_cr) st <= PS_IDLE;
                        else if (is_sign && idx_acc < IDX_LIM) begin
                            rise_q <= cls.is_plus;
                            st     <= PS_D_END;
                        end else st <= PS_SKIP;
                    end
                    PS_D_END: st <= cls.is_cr ? PS_IDLE : PS_SKIP;
                    PS_SKIP:  if (cls.is_cr) st <= PS_IDLE;
                    default:  st <= PS_IDLE;
                endcase
            end
        end
    end

    // R8
    mask_src_chk: assert property (@(posedge clk) disable iff (rst)
        mask_we |-> $past(acc && cls.is_cr));

    // R7
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mask_we, edge_we, cos_clr}));

    // R5
    edge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        edge_we |=> !edge_we);

endmodule

// File: rtl/ioc_reply_tx.sv
module ioc_reply_tx
    import ioc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rep_req,
    input  reply_e     rep_kind,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       busy
);
    logic [7:0] byte0, byte1;
    logic [1:0] left;

    assign tx_valid = (left != 2'd0);
    assign tx_data  = byte0;
    assign busy     = tx_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte0 <= '0;
            byte1 <= '0;
            left  <= '0;
        end else if (rep_req) begin
            case (rep_kind)
                RK_YES: begin byte0 <= CH_YES; byte1 <= CH_CR; left <= 2'd2; end
                RK_NO:  begin byte0 <= CH_NO;  byte1 <= CH_CR; left <= 2'd2; end
                default: begin byte0 <= CH_CR; byte1 <= CH_CR; left <= 2'd1; end
            endcase
        end else if (tx_valid && tx_ready) begin
            byte0 <= byte1;
            left  <= left - 2'd1;
        end
    end

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R9
    req_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rep_req |-> left == 2'd0);

endmodule

// File: rtl/ioc_cmd_decoder.sv
module ioc_cmd_decoder
    import ioc_pkg::*;
#(
    parameter int N_BITS = 8,
    localparam int IDX_W = (N_BITS > 1) ? $clog2(N_BITS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    input  logic              cos_flag,
    output logic              cos_clr,
    output logic              mask_we,
    output logic [N_BITS-1:0] mask_data,
    output logic              edge_we,
    output logic [IDX_W-1:0]  edge_idx,
    output logic              edge_rise,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready
);
    chclass_t cls;
    logic     acc;
    logic     rep_req;
    reply_e   rep_kind;
    logic     busy;

    assign rx_ready = !busy;
    assign acc      = rx_valid && rx_ready;

    ioc_char_class u_class (
        .ch  (rx_data),
        .cls (cls)
    );

    ioc_parser #(.N_BITS(N_BITS), .IDX_W(IDX_W)) u_parser (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .cls       (cls),
        .cos_flag  (cos_flag),
        .mask_we   (mask_we),
        .mask_data (mask_data),
        .edge_we   (edge_we),
        .edge_idx  (edge_idx),
        .edge_rise (edge_rise),
        .cos_clr   (cos_clr),
        .rep_req   (rep_req),
        .rep_kind  (rep_kind)
    );

    ioc_reply_tx u_reply (
        .clk      (clk),
        .rst      (rst),
        .rep_req  (rep_req),
        .rep_kind (rep_kind),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .busy     (busy)
    );

    // R2
    status_byte_chk: assert property (@(posedge clk) disable iff (rst)
        cos_clr && $past(cos_flag) |-> tx_valid && tx_data == CH_YES);

    // R8
    reply_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_we || edge_we || cos_clr) |-> tx_valid);

endmodule

// File: tb/ioc_cmd_decoder_tb.sv
module ioc_cmd_decoder_tb;
    localparam int N_BITS = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_ready;
    logic       cos_flag = 1'b0;
    logic       cos_clr;
    logic       mask_we;
    logic [7:0] mask_data;
    logic       edge_we;
    logic [2:0] edge_idx;
    logic       edge_rise;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    bit running = 1'b0;

    logic [7:0] exp_tx[$];
    logic [7:0] exp_mask[$];
    logic [3:0] exp_edge[$];
    int         exp_cos = 0;

    always #10 clk = ~clk;

    ioc_cmd_decoder #(.N_BITS(N_BITS)) u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .cos_flag(cos_flag), .cos_clr(cos_clr),
        .mask_we(mask_we), .mask_data(mask_data), .edge_we(edge_we),
        .edge_idx(edge_idx), .edge_rise(edge_rise), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (running) tx_ready = ($urandom_range(3) != 0);
    end

    // Monitor: scoreboard compare at negedge
    logic       prev_stall = 1'b0;
    logic [7:0] prev_data  = 8'h00;
    always @(negedge clk) begin
        if (!rst && running) begin
            if (prev_stall)
                chk(tx_valid && tx_data == prev_data, "R9", "held byte",
                    {tx_valid, tx_data}, {1'b1, prev_data});
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0) chk(1'b0, "R7", "unexpected reply byte", tx_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_tx.pop_front();
                    chk(tx_data == e, "R9", "reply byte", tx_data, e);
                end
            end
            if (mask_we) begin
                if (exp_mask.size() == 0) chk(1'b0, "R7", "unexpected mask_we", mask_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_mask.pop_front();
                    chk(mask_data == e, "R3", "mask_data", mask_data, e);
                end
            end
            if (edge_we) begin
                if (exp_edge.size() == 0) chk(1'b0, "R7", "unexpected edge_we", edge_idx, 0);
                else begin
                    logic [3:0] e;
                    e = exp_edge.pop_front();
                    chk({edge_rise, edge_idx} == e, "R5", "edge fields",
                        {edge_rise, edge_idx}, e);
                end
            end
            if (cos_clr) begin
                chk(exp_cos > 0, "R2", "cos_clr pulse", 1, exp_cos);
                if (exp_cos > 0) exp_cos--;
            end
        end
    end

    task automatic put_char(input logic [7:0] c);
        @(posedge clk); #2;
        rx_valid = 1'b1;
        rx_data  = c;
        forever begin
            @(negedge clk);
            if (rx_ready) break;
        end
        @(posedge clk); #2;
        rx_valid = 1'b0;
    endtask

    task automatic put_str(input string s);
        for (int i = 0; i < s.len(); i++) put_char(s[i]);
    endtask

    // valid command: strobe and first reply byte due one cycle after CR (R8)
    task automatic good_cmd(input string s, input string req);
        put_str(s);
        @(negedge clk);
        chk((mask_we || edge_we || cos_clr) && tx_valid, "R8",
            {req, " strobe+reply timing"}, {mask_we, edge_we, cos_clr, tx_valid}, 1);
    endtask

    task automatic bad_cmd(input string s);
        put_str(s);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!tx_valid && !mask_we && !edge_we && !cos_clr, "R7",
                {"no action for ", s}, {tx_valid, mask_we, edge_we, cos_clr}, 0);
        end
    endtask

    task automatic edge_cmd(input string s, input logic rise, input logic [2:0] idx,
                            input string req);
        exp_edge.push_back({rise, idx});
        exp_tx.push_back(8'h0D);
        good_cmd(s, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!tx_valid, "R1", "tx_valid after reset", tx_valid, 0);
        chk(rx_ready, "R1", "rx_ready after reset", rx_ready, 1);
        chk(!mask_we && !edge_we && !cos_clr, "R1", "strobes after reset",
            {mask_we, edge_we, cos_clr}, 0);
        running = 1'b1;

        // R2: read with flag low, then high (lower-case letter, R4)
        cos_flag = 1'b0;
        exp_tx.push_back(8'h4E); exp_tx.push_back(8'h0D); exp_cos++;
        good_cmd("Y\015", "R2");
        cos_flag = 1'b1;
        exp_tx.push_back(8'h59); exp_tx.push_back(8'h0D); exp_cos++;
        good_cmd("y\015", "R2 R4");
        cos_flag = 1'b0;

        // R3 / R4: mask writes
        exp_mask.push_back(8'hA5); exp_tx.push_back(8'h0D);
        good_cmd("TA5\015", "R3");
        exp_mask.push_back(8'h3C); exp_tx.push_back(8'h0D);
        good_cmd("t3c\015", "R4");
        exp_mask.push_back(8'hFF); exp_tx.push_back(8'h0D);
        good_cmd("TfF\015", "R4");

        // R5 / R6: edge selects
        edge_cmd("D1+\015",  1'b1, 3'd1, "R5");
        edge_cmd("D01+\015", 1'b1, 3'd1, "R6");
        edge_cmd("d7-\015",  1'b0, 3'd7, "R5");
        edge_cmd("D00-\015", 1'b0, 3'd0, "R6");
        edge_cmd("D5-\015",  1'b0, 3'd5, "R6");
        edge_cmd("d05-\015", 1'b0, 3'd5, "R6");

        // R7: malformed commands
        bad_cmd("TG1\015");
        bad_cmd("TA\015");
        bad_cmd("TA55\015");
        bad_cmd("D1\015");
        bad_cmd("D8+\015");
        bad_cmd("D09+\015");
        bad_cmd("D123+\015");
        bad_cmd("X\015");
        bad_cmd("\015");
        bad_cmd("Y1\015");
        bad_cmd("D2+x\015");

        // R7: parser back to idle
        exp_mask.push_back(8'h5A); exp_tx.push_back(8'h0D);
        good_cmd("T5a\015", "R7 recovery");
        cos_flag = 1'b1;
        exp_tx.push_back(8'h59); exp_tx.push_back(8'h0D); exp_cos++;
        good_cmd("Y\015", "R2");
        cos_flag = 1'b0;

        for (int w = 0; w < 50 && exp_tx.size() != 0; w++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_tx.size() == 0, "R9", "reply bytes outstanding", exp_tx.size(), 0);
        chk(exp_mask.size() == 0, "R3", "mask writes outstanding", exp_mask.size(), 0);
        chk(exp_edge.size() == 0, "R5", "edge writes outstanding", exp_edge.size(), 0);
        chk(exp_cos == 0, "R2", "cos_clr outstanding", exp_cos, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule